// File: doc/BRIEF.md
# Serial Bit-Clock Source Selector

This block decides where one serial channel gets its receive and transmit bit timing. Every result is a single-cycle enable on the system clock. No derived clock is ever gated. External receive and transmit clocks and a carrier-detect line come in asynchronously. Each passes through a two-flop synchronizer, and the clock inputs are then edge-detected. A digital PLL living elsewhere receives a 16x reference enable from the block's baud-rate divider, and returns a recovered receive enable.

A two-bit mode field and a source-select bit pick one of four arrangements:
- External clocking qualified per bit by strobes.
- Receive timing from the DPLL.
- Both directions from the DPLL or straight from the divider.
- Both directions at the full oscillator rate, where the system clock is the oscillator.

Whenever the transmit timing is produced internally, a toggling copy is offered on a transmit-clock output together with its drive enable. Changing the mode or the source-select bit restarts the divider chain.

Top module: `sclk_src_sel`

## Requirements
- R1: After reset, with mode 0 and all external inputs low, every enable output, `txclk_oe_o` and `txclk_out_o` stay low.
- R2: Mode 0 (strobe). Each rising edge of `ext_rxclk_i` gives exactly one `rx_en_o` pulse when `cd_strobe_i` is high at that edge. It gives exactly one `tx_en_o` pulse when `ext_txclk_i` is high at that edge. A clock held high gives only one pulse.
- R3: The baud-rate divider counts rising edges of `ext_rxclk_i`. It emits one pulse per `brg_div_i`+1 edges, so a value of 0 gives a pulse on every edge. These pulses appear on `ref16_en_o` in mode 1, and in mode 2 with select clear. In every other case `ref16_en_o` stays low.
- R4: Mode 1. `rx_en_o` follows `dpll_rx_en_i`.
- R5: Mode 1, transmit side.
  - With select clear, `tx_en_o` pulses once per rising edge of `ext_txclk_i`.
  - With select set, `tx_en_o` pulses once per 16 divider pulses.
- R6: Mode 2.
  - With select clear, both `rx_en_o` and `tx_en_o` follow `dpll_rx_en_i`.
  - With select set, both follow the divider pulses and `ref16_en_o` stays low.
- R7: Mode 3. `rx_en_o` and `tx_en_o` are high on every cycle.
- R8: `txclk_oe_o` is high in mode 1 with select set, and in modes 2 and 3; it is low otherwise.
  - `txclk_out_o` toggles once for each `tx_en_o` pulse while `txclk_oe_o` is high.
  - `txclk_out_o` holds while `txclk_oe_o` is low.
- R9: Any change of mode or select reloads the divider from `brg_div_i` and clears the divide-by-16 stage. The first pulse afterwards therefore needs a full `brg_div_i`+1 edges, or a full 16 divider pulses.
- R10: Every edge-derived enable lasts one system cycle and never occurs on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (also the oscillator source) |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_rxclk_i | input | 1 | Asynchronous external receive clock |
| ext_txclk_i | input | 1 | Asynchronous external transmit clock or transmit strobe |
| cd_strobe_i | input | 1 | Asynchronous receive strobe on the carrier-detect line |
| dpll_rx_en_i | input | 1 | Recovered receive enable from the DPLL, synchronous |
| mode_i | input | 2 | 0 strobe, 1 receive-DPLL, 2 full-DPLL, 3 oscillator |
| src_sel_i | input | 1 | Source select within modes 1 and 2 |
| brg_div_i | input | 10 | Divider reload value |
| rx_en_o | output | 1 | Receive bit enable |
| tx_en_o | output | 1 | Transmit bit enable |
| ref16_en_o | output | 1 | 16x reference enable for the DPLL |
| txclk_out_o | output | 1 | Internally derived transmit clock level |
| txclk_oe_o | output | 1 | Drive enable for `txclk_out_o` |

## Verification
Pulses are counted over windows of synthetic bit slots in every mode and select setting, with reload values 0 to 3. The counts are compared with ratios computed from the stimulus.
- With reload value 0, a divider that is off by one would double or halve the reference count.
- In the strobe test, a strobe synchronized with a different delay than its clock would qualify the wrong slot, and the receive and transmit counts would no longer match the random strobe pattern.
- For the restart check, a partial divider count is left behind and then the mode is changed. A design that keeps the stale count emits an early reference pulse.
- An output-enable decode that is wrong for any mode shows up as stray or missing toggles on the transmit-clock output.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
   typedef enum logic [1:0] {
      MODE_STROBE  = 2'd0,
      MODE_RXPLL   = 2'd1,
      MODE_FULLPLL = 2'd2,
      MODE_OSC     = 2'd3
   } clk_mode_e;

   localparam int unsigned SYNC_STAGES_DEF = 2;
   localparam int unsigned DIV_W_DEF       = 10;
   localparam int unsigned PRE_W_DEF       = 4;
endpackage

// File: rtl/sclk_sync_bank.sv
module sclk_sync_bank #(
   parameter int unsigned N      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] lvl_o
);
   initial begin
      assert (STAGES >= 2) else $error("sync bank needs at least two stages");
      assert (N >= 1) else $error("sync bank needs at least one input");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
      end
      assign lvl_o[g] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/sclk_edge_rise.sv
module sclk_edge_rise #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   for (genvar g = 0; g < N; g++) begin : g_edge
      assign rise_o[g] = lvl_i[g] & ~prev_q[g];

      assert_single_pulse_R10 : assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[g] |=> !rise_o[g]);
   end
endmodule

// File: rtl/sclk_brg.sv
module sclk_brg #(
   parameter int unsigned DIV_W = 10,
   parameter int unsigned PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             brg_en_o,
   output logic             brg16_en_o
);
   localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 24) else $error("divider width out of range");
      assert (PRE_W >= 1) else $error("prescale width out of range");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [PRE_W-1:0] pre_q;
   logic             term;

   assign term       = tick_i && (cnt_q == '0) && !clr_i;
   assign brg_en_o   = term;
   assign brg16_en_o = term && (pre_q == PRE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pre_q <= '0;
      end else if (clr_i) begin
         cnt_q <= div_i;
         pre_q <= '0;
      end else begin
         if (tick_i) begin
            if (cnt_q == '0) cnt_q <= div_i;
            else             cnt_q <= cnt_q - 1'b1;
         end
         if (term) pre_q <= pre_q + 1'b1;
      end
   end

   assert_div16_subset_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      brg16_en_o |-> brg_en_o);

   assert_restart_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && div_i != '0) |=> !brg_en_o);
endmodule

// File: rtl/sclk_route.sv
module sclk_route
   import sclk_pkg::*;
(
   input  clk_mode_e mode_i,
   input  logic      sel_i,
   input  logic      rx_rise_i,
   input  logic      tx_rise_i,
   input  logic      cd_lvl_i,
   input  logic      ts_lvl_i,
   input  logic      dpll_en_i,
   input  logic      brg_en_i,
   input  logic      brg16_en_i,
   output logic      rx_en_o,
   output logic      tx_en_o,
   output logic      ref_en_o,
   output logic      oe_o
);
   always_comb begin
      rx_en_o  = 1'b0;
      tx_en_o  = 1'b0;
      ref_en_o = 1'b0;
      oe_o     = 1'b0;
      unique case (mode_i)
         MODE_STROBE: begin
            rx_en_o = rx_rise_i & cd_lvl_i;
            tx_en_o = rx_rise_i & ts_lvl_i;
         end
         MODE_RXPLL: begin
            ref_en_o = brg_en_i;
            rx_en_o  = dpll_en_i;
            tx_en_o  = sel_i ? brg16_en_i : tx_rise_i;
            oe_o     = sel_i;
         end
         MODE_FULLPLL: begin
            ref_en_o = sel_i ? 1'b0 : brg_en_i;
            rx_en_o  = sel_i ? brg_en_i : dpll_en_i;
            tx_en_o  = rx_en_o;
            oe_o     = 1'b1;
         end
         MODE_OSC: begin
            rx_en_o = 1'b1;
            tx_en_o = 1'b1;
            oe_o    = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sclk_src_sel.sv
module sclk_src_sel
   import sclk_pkg::*;
#(
   parameter int unsigned DIV_W       = DIV_W_DEF,
   parameter int unsigned PRE_W       = PRE_W_DEF,
   parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rxclk_i,
   input  logic             ext_txclk_i,
   input  logic             cd_strobe_i,
   input  logic             dpll_rx_en_i,
   input  logic [1:0]       mode_i,
   input  logic             src_sel_i,
   input  logic [DIV_W-1:0] brg_div_i,
   output logic             rx_en_o,
   output logic             tx_en_o,
   output logic             ref16_en_o,
   output logic             txclk_out_o,
   output logic             txclk_oe_o
);
   localparam int unsigned N_ASYNC = 3;
   localparam int unsigned IX_RX   = 0;
   localparam int unsigned IX_TX   = 1;
   localparam int unsigned IX_CD   = 2;

   logic [N_ASYNC-1:0] lvl;
   logic [1:0]         rise;
   logic [2:0]         cfg_q;
   logic               cfg_chg;
   logic               brg_en, brg16_en;
   logic               txo_q;
   clk_mode_e          mode;

   assign mode = clk_mode_e'(mode_i);

   sclk_sync_bank #(.N(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({cd_strobe_i, ext_txclk_i, ext_rxclk_i}),
      .lvl_o   (lvl)
   );

   sclk_edge_rise #(.N(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({lvl[IX_TX], lvl[IX_RX]}),
      .rise_o (rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= {mode_i, src_sel_i};
   end
   assign cfg_chg = (cfg_q != {mode_i, src_sel_i});

   sclk_brg #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_brg (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (rise[0]),
      .clr_i      (cfg_chg),
      .div_i      (brg_div_i),
      .brg_en_o   (brg_en),
      .brg16_en_o (brg16_en)
   );

   sclk_route u_route (
      .mode_i     (mode),
      .sel_i      (src_sel_i),
      .rx_rise_i  (rise[0]),
      .tx_rise_i  (rise[1]),
      .cd_lvl_i   (lvl[IX_CD]),
      .ts_lvl_i   (lvl[IX_TX]),
      .dpll_en_i  (dpll_rx_en_i),
      .brg_en_i   (brg_en),
      .brg16_en_i (brg16_en),
      .rx_en_o    (rx_en_o),
      .tx_en_o    (tx_en_o),
      .ref_en_o   (ref16_en_o),
      .oe_o       (txclk_oe_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      txo_q <= 1'b0;
      else if (tx_en_o && txclk_oe_o)  txo_q <= ~txo_q;
   end
   assign txclk_out_o = txo_q;

   assert_osc_full_rate_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd3) |-> (rx_en_o && tx_en_o));

   assert_strobe_no_drive_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd0) |-> !txclk_oe_o);

   assert_txclk_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(txclk_oe_o) |-> $stable(txclk_out_o));

   assert_ref_quiet_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd0 || mode_i == 2'd3) |-> !ref16_en_o);
endmodule

// File: tb/sclk_src_sel_test.sv
module sclk_src_sel_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_rxclk = 1'b0, ext_txclk = 1'b0, cd_strobe = 1'b0, dpll_en = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       sel = 1'b0;
   logic [9:0] div = 10'd0;
   logic       rx_en, tx_en, ref_en, txo, oe;

   int unsigned n_run = 0, n_fail = 0;
   int unsigned c_rx, c_tx, c_ref, c_tog, c_cyc;
   bit          count_on = 1'b0;
   logic        txo_prev = 1'b0;
   int unsigned cyc_total = 0;
   int unsigned seed_dummy;

   always #2.5 clk = ~clk;

   sclk_src_sel uut (
      .clk(clk), .rst_n(rst_n), .ext_rxclk_i(ext_rxclk), .ext_txclk_i(ext_txclk),
      .cd_strobe_i(cd_strobe), .dpll_rx_en_i(dpll_en), .mode_i(mode), .src_sel_i(sel),
      .brg_div_i(div), .rx_en_o(rx_en), .tx_en_o(tx_en), .ref16_en_o(ref_en),
      .txclk_out_o(txo), .txclk_oe_o(oe)
   );

   always @(negedge clk) begin
      cyc_total <= cyc_total + 1;
      if (count_on) begin
         c_cyc <= c_cyc + 1;
         c_rx  <= c_rx + int'(rx_en);
         c_tx  <= c_tx + int'(tx_en);
         c_ref <= c_ref + int'(ref_en);
         c_tog <= c_tog + int'(txo != txo_prev);
      end
      txo_prev <= txo;
   end

   task automatic check(input string req, input int unsigned act, input int unsigned exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   function automatic int unsigned exp_rx(int m, bit s, int unsigned ncd, int unsigned ndp,
                                          int unsigned brg, int unsigned cyc);
      case (m)
         0: return ncd;
         1: return ndp;
         2: return s ? brg : ndp;
         default: return cyc;
      endcase
   endfunction

   function automatic int unsigned exp_tx(int m, bit s, int unsigned nts, int unsigned ndp,
                                          int unsigned brg, int unsigned cyc);
      case (m)
         0: return nts;
         1: return s ? brg / 16 : nts;
         2: return s ? brg : ndp;
         default: return cyc;
      endcase
   endfunction

   function automatic int unsigned exp_ref(int m, bit s, int unsigned brg);
      if (m == 1 || (m == 2 && !s)) return brg;
      return 0;
   endfunction

   function automatic bit exp_oe(int m, bit s);
      return (m == 2 || m == 3 || (m == 1 && s));
   endfunction

   // One bit slot of 8 cycles; receive clock pulses in cycles 1..4.
   task automatic slot(input bit cdb, input bit tsb, input bit tx_is_clk, input bit dpb);
      cd_strobe = cdb;
      ext_txclk = tx_is_clk ? 1'b0 : tsb;
      ext_rxclk = 1'b0;
      step(1);
      ext_rxclk = 1'b1;
      if (tx_is_clk) ext_txclk = tsb;
      step(1);
      dpll_en = dpb;
      step(1);
      dpll_en = 1'b0;
      step(2);
      ext_rxclk = 1'b0;
      if (tx_is_clk) ext_txclk = 1'b0;
      step(3);
   endtask

   task automatic run_case(input string tag, input int m, input bit s, input int d,
                           input int nslot, input bit scrub);
      int unsigned ncd = 0, nts = 0, ndp = 0, brg;
      bit          eoe;
      if (scrub) begin
         mode = (m == 3) ? 2'd0 : 2'd3;
         step(3);
      end
      div  = 10'(d);
      mode = 2'(m);
      sel  = s;
      step(4);
      c_rx = 0; c_tx = 0; c_ref = 0; c_tog = 0; c_cyc = 0;
      @(posedge clk); #1;
      count_on = 1'b1;
      for (int k = 0; k < nslot; k++) begin
         bit b_cd = 1'($urandom);
         bit b_ts = 1'($urandom);
         bit b_dp = 1'($urandom);
         ncd += b_cd; nts += b_ts; ndp += b_dp;
         slot(b_cd, b_ts, (m == 1), b_dp);
      end
      step(5);
      @(negedge clk); #1;
      count_on = 1'b0;
      brg = nslot / (d + 1);
      eoe = exp_oe(m, s);
      check({tag, " rx"}, c_rx, exp_rx(m, s, ncd, ndp, brg, c_cyc));
      check({tag, " tx"}, c_tx, exp_tx(m, s, nts, ndp, brg, c_cyc));
      check({tag, " ref16"}, c_ref, exp_ref(m, s, brg));
      check({"R8 oe ", tag}, int'(oe), int'(eoe));
      check({"R8 toggles ", tag}, c_tog, eoe ? exp_tx(m, s, nts, ndp, brg, c_cyc) : 0);
      @(posedge clk); #1;
   endtask

   initial begin
      for (int w = 0; w < 150000; w++) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'd1234);
      step(4);
      rst_n = 1'b1;
      step(2);
      c_rx = 0; c_tx = 0; c_ref = 0; c_tog = 0; c_cyc = 0;
      count_on = 1'b1;
      step(10);
      count_on = 1'b0;
      check("R1 rx quiet after reset", c_rx + c_tx + c_ref, 0);
      check("R1 oe low after reset", int'(oe), 0);
      check("R1 txclk_out low after reset", int'(txo), 0);

      run_case("R2 strobe", 0, 1'b0, 2, 40, 1'b1);
      run_case("R10 strobe single pulse", 0, 1'b1, 0, 30, 1'b1);
      run_case("R3 R4 R5 rxpll ext tx", 1, 1'b0, 1, 40, 1'b1);
      run_case("R3 R5 rxpll div16 tx", 1, 1'b1, 0, 50, 1'b1);
      run_case("R6 fullpll dpll", 2, 1'b0, 3, 40, 1'b1);
      run_case("R6 fullpll direct", 2, 1'b1, 1, 40, 1'b1);
      run_case("R7 osc", 3, 1'b0, 0, 10, 1'b1);
      run_case("R3 div zero", 2, 1'b0, 0, 25, 1'b1);
      // R9: leave a partial count, then a config change must restart it
      run_case("R9 partial", 2, 1'b1, 3, 2, 1'b1);
      run_case("R9 restart", 1, 1'b1, 3, 3, 1'b0);

      for (int it = 0; it < 14; it++) begin
         int m = int'($urandom_range(0, 3));
         bit s = 1'($urandom);
         int d = int'($urandom_range(0, 3));
         int n = int'($urandom_range(20, 70));
         run_case("R2 R3 R6 R7 random", m, s, d, n, 1'b1);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule